// File: doc/BRIEF.md
# Serial Hex Capture Frame Decoder

This block listens to one asynchronous serial line that carries logic-analyser capture dumps and rebuilds each capture as a table of 16-bit samples in local memory. Every sample travels as four printable hexadecimal characters, most significant nibble first. A line feed closes each dump. The block contains its own receiver, running at a bit period of `CLK_HZ / BAUD` clock cycles. It turns each hex character into a nibble and packs every four nibbles into one sample word.

The link has no flow control, so characters can go missing. For that reason a dump is kept only when exactly `4 * DEPTH` hex characters arrive between two line feeds and no character was received with a broken stop bit. Samples land in a write bank first. A dump that passes is made visible by swapping the write bank with the read bank, so a dump that fails leaves the last good capture untouched. Each swap raises a one-cycle `frame_valid` pulse and advances a wrapping frame counter. A constant output gives the sample index of the trigger point, which is the middle of the capture.

Top module: `hexcap_rx`

## Requirements
- R1: The receiver takes 8N1 bytes, least significant data bit first, with a bit period of CLK_HZ/BAUD clocks. It confirms a start bit half a bit period after the falling edge.
- R2: Bytes 0x30..0x39 decode to nibbles 0..9 and bytes 0x41..0x46 decode to 10..15. The four characters of a sample arrive most significant nibble first, and sample k of a committed frame is read at address k.
- R3: A frame is committed only when exactly 4*DEPTH hex characters have been seen since the previous line feed (0x0A) or since reset. Shorter and longer frames are discarded.
- R4: Every other byte is ignored and is not counted toward the frame length. This includes carriage return (0x0D), space and the lowercase letters 0x61..0x66.
- R5: A byte whose stop bit samples low is dropped and marks the current frame invalid until the next line feed. After such a byte the receiver waits for the line to return high before it looks for a new start bit.
- R6: Each commit produces a `frame_valid` pulse exactly one cycle wide, and `frame_count` increases by one (modulo 2^CNT_W) on that pulse and at no other time.
- R7: The read port returns the most recently committed frame with one cycle of latency from `rd_addr`. Discarded or partial frames never change what it returns.
- R8: After reset `rd_ok` and `frame_count` are zero. `rd_ok` rises together with the first commit and stays high after that.
- R9: `trig_idx` always equals DEPTH/2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| serial_in | input | 1 | Asynchronous serial line, idle high |
| rd_addr | input | $clog2(DEPTH) | Sample index to read |
| rd_data | output | SW | Sample at `rd_addr`, one cycle later |
| rd_ok | output | 1 | Read bank holds a committed frame |
| frame_valid | output | 1 | One-cycle pulse on each commit |
| frame_count | output | CNT_W | Number of commits, wrapping |
| trig_idx | output | $clog2(DEPTH) | Sample index of the trigger point |

## Verification
The hardest case to reach is a frame that has exactly the right number of hex characters but still has to be discarded. A byte with a low stop bit causes this. The bench serialises a space character with its stop bit forced low inside an otherwise perfect frame, holds the line low for a full bit time, and then releases it. This tests both the invalid flag and the receiver's wait for the line to return high. Neighbouring cases also leave the count at exactly the expected value while changing what is counted: a lowercase letter that must not count, and carriage returns and spaces scattered between samples that must be skipped. After each discarded frame the whole read bank is read back and compared with the previous good capture.

// File: rtl/hexcap_pkg.sv
package hexcap_pkg;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_START,
    RX_DATA,
    RX_STOP,
    RX_BREAK
  } rx_state_e;

  localparam logic [7:0] CH_LF = 8'h0A;

  // true for '0'..'9' and 'A'..'F'
  function automatic logic is_hex(input logic [7:0] c);
    return ((c >= 8'h30) && (c <= 8'h39)) || ((c >= 8'h41) && (c <= 8'h46));
  endfunction

  function automatic logic [3:0] hex_nib(input logic [7:0] c);
    if (c <= 8'h39) return c[3:0];
    return c[3:0] + 4'd9;
  endfunction

endpackage

// File: rtl/hcr_uart_rx.sv
module hcr_uart_rx
  import hexcap_pkg::*;
#(
  parameter int DIV = 1666
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_i,
  output logic [7:0] byte_o,
  output logic       vld_o,
  output logic       err_o
);

  localparam int CW   = $clog2(DIV + 1);
  localparam int HALF = DIV / 2 - 1;

  logic [1:0]    sync_q;
  logic          rx_s;
  rx_state_e     st_q, st_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [2:0]    bit_q, bit_n;
  logic [7:0]    sh_q, sh_n;
  logic          vld_q, vld_n, err_q, err_n;
  logic          bit_end, half_end;

  assign rx_s     = sync_q[1];
  assign bit_end  = (cnt_q == CW'(DIV - 1));
  assign half_end = (cnt_q == CW'(HALF));

  always_comb begin
    st_n  = st_q;
    cnt_n = cnt_q;
    bit_n = bit_q;
    sh_n  = sh_q;
    vld_n = 1'b0;
    err_n = 1'b0;
    unique case (st_q)
      RX_IDLE: begin
        cnt_n = '0;
        if (!rx_s) st_n = RX_START;
      end
      RX_START: begin
        if (half_end) begin
          cnt_n = '0;
          bit_n = '0;
          st_n  = rx_s ? RX_IDLE : RX_DATA;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      RX_DATA: begin
        if (bit_end) begin
          cnt_n = '0;
          sh_n  = {rx_s, sh_q[7:1]};
          if (bit_q == 3'd7) st_n = RX_STOP;
          else bit_n = bit_q + 1'b1;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      RX_STOP: begin
        if (bit_end) begin
          cnt_n = '0;
          if (rx_s) begin
            vld_n = 1'b1;
            st_n  = RX_IDLE;
          end else begin
            err_n = 1'b1;
            st_n  = RX_BREAK;
          end
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      RX_BREAK: begin
        if (rx_s) st_n = RX_IDLE;
      end
      default: st_n = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      st_q   <= RX_IDLE;
      cnt_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      vld_q  <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], line_i};
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      bit_q  <= bit_n;
      sh_q   <= sh_n;
      vld_q  <= vld_n;
      err_q  <= err_n;
    end
  end

  assign byte_o = sh_q;
  assign vld_o  = vld_q;
  assign err_o  = err_q;

endmodule

// File: rtl/hcr_framer.sv
module hcr_framer
  import hexcap_pkg::*;
#(
  parameter int DEPTH = 1024,
  parameter int SW    = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ch_vld,
  input  logic                     ch_err,
  input  logic [7:0]               ch,
  output logic                     wr_en,
  output logic [$clog2(DEPTH)-1:0] wr_addr,
  output logic [SW-1:0]            wr_data,
  output logic                     commit
);

  localparam int AW    = $clog2(DEPTH);
  localparam int NPS   = SW / 4;
  localparam int NPW   = $clog2(NPS);
  localparam int NCHAR = DEPTH * NPS;
  localparam int CCW   = $clog2(NCHAR + 2);

  logic [CCW-1:0] cnt_q, cnt_n;
  logic           bad_q, bad_n;
  logic [SW-5:0]  acc_q, acc_n;
  logic           wen_q, wen_n;
  logic [AW-1:0]  wa_q, wa_n;
  logic [SW-1:0]  wd_q, wd_n;
  logic           cm_q, cm_n;
  logic [3:0]     nib;
  logic [NPW-1:0] pos;

  assign nib = hex_nib(ch);
  assign pos = cnt_q[NPW-1:0];

  always_comb begin
    cnt_n = cnt_q;
    bad_n = bad_q;
    acc_n = acc_q;
    wen_n = 1'b0;
    wa_n  = wa_q;
    wd_n  = wd_q;
    cm_n  = 1'b0;
    if (ch_err) begin
      bad_n = 1'b1;
    end else if (ch_vld) begin
      if (ch == CH_LF) begin
        cm_n  = !bad_q && (cnt_q == CCW'(NCHAR));
        cnt_n = '0;
        bad_n = 1'b0;
      end else if (is_hex(ch)) begin
        if (cnt_q < CCW'(NCHAR)) begin
          if (pos == NPW'(NPS - 1)) begin
            wen_n = 1'b1;
            wa_n  = AW'(cnt_q >> NPW);
            wd_n  = {acc_q, nib};
          end else begin
            acc_n = {acc_q[SW-9:0], nib};
          end
        end
        if (cnt_q != CCW'(NCHAR + 1)) cnt_n = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      bad_q <= 1'b0;
      acc_q <= '0;
      wen_q <= 1'b0;
      wa_q  <= '0;
      wd_q  <= '0;
      cm_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_n;
      bad_q <= bad_n;
      acc_q <= acc_n;
      wen_q <= wen_n;
      wa_q  <= wa_n;
      wd_q  <= wd_n;
      cm_q  <= cm_n;
    end
  end

  assign wr_en   = wen_q;
  assign wr_addr = wa_q;
  assign wr_data = wd_q;
  assign commit  = cm_q;

endmodule

// File: rtl/hcr_banks.sv
module hcr_banks #(
  parameter int DEPTH = 1024,
  parameter int SW    = 16,
  parameter int CNT_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [$clog2(DEPTH)-1:0] wr_addr,
  input  logic [SW-1:0]            wr_data,
  input  logic                     commit,
  input  logic [$clog2(DEPTH)-1:0] rd_addr,
  output logic [SW-1:0]            rd_data,
  output logic                     rd_ok,
  output logic                     frame_valid,
  output logic [CNT_W-1:0]         frame_count
);

  logic             sel_q, sel_n;
  logic             ok_q, ok_n;
  logic             fv_q, fv_n;
  logic [CNT_W-1:0] fc_q, fc_n;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    localparam logic MINE = (b == 1);
    logic [SW-1:0] arr [DEPTH];
    logic [SW-1:0] rdq;
    always_ff @(posedge clk) begin
      if (wr_en && (sel_q != MINE)) arr[wr_addr] <= wr_data;
      rdq <= arr[rd_addr];
    end
  end

  assign rd_data = sel_q ? g_bank[1].rdq : g_bank[0].rdq;

  always_comb begin
    sel_n = sel_q;
    ok_n  = ok_q;
    fc_n  = fc_q;
    fv_n  = 1'b0;
    if (commit) begin
      sel_n = !sel_q;
      ok_n  = 1'b1;
      fc_n  = fc_q + 1'b1;
      fv_n  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
      ok_q  <= 1'b0;
      fv_q  <= 1'b0;
      fc_q  <= '0;
    end else begin
      sel_q <= sel_n;
      ok_q  <= ok_n;
      fv_q  <= fv_n;
      fc_q  <= fc_n;
    end
  end

  assign rd_ok       = ok_q;
  assign frame_valid = fv_q;
  assign frame_count = fc_q;

endmodule

// File: rtl/hexcap_rx.sv
module hexcap_rx #(
  parameter int CLK_HZ = 32_000_000,
  parameter int BAUD   = 19_200,
  parameter int DEPTH  = 1024,
  parameter int SW     = 16,
  parameter int CNT_W  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     serial_in,
  input  logic [$clog2(DEPTH)-1:0] rd_addr,
  output logic [SW-1:0]            rd_data,
  output logic                     rd_ok,
  output logic                     frame_valid,
  output logic [CNT_W-1:0]         frame_count,
  output logic [$clog2(DEPTH)-1:0] trig_idx
);

  localparam int DIV = CLK_HZ / BAUD;
  localparam int AW  = $clog2(DEPTH);

  logic [1:0]    rs_q;
  logic          rst_core_n;
  logic [7:0]    rx_byte;
  logic          rx_vld, rx_err;
  logic          wr_en, commit;
  logic [AW-1:0] wr_addr;
  logic [SW-1:0] wr_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_core_n = rs_q[1];

  hcr_uart_rx #(.DIV(DIV)) u_rx (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .line_i (serial_in),
    .byte_o (rx_byte),
    .vld_o  (rx_vld),
    .err_o  (rx_err)
  );

  hcr_framer #(.DEPTH(DEPTH), .SW(SW)) u_frm (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .ch_vld  (rx_vld),
    .ch_err  (rx_err),
    .ch      (rx_byte),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .commit  (commit)
  );

  hcr_banks #(.DEPTH(DEPTH), .SW(SW), .CNT_W(CNT_W)) u_bank (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .commit      (commit),
    .rd_addr     (rd_addr),
    .rd_data     (rd_data),
    .rd_ok       (rd_ok),
    .frame_valid (frame_valid),
    .frame_count (frame_count)
  );

  assign trig_idx = AW'(DEPTH / 2);

endmodule

// File: rtl/hexcap_rx_chk.sv
module hexcap_rx_chk #(
  parameter int DEPTH = 1024,
  parameter int SW    = 16,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_vld,
  input logic             rx_err,
  input logic [7:0]       rx_byte,
  input logic             frame_valid,
  input logic [CNT_W-1:0] frame_count,
  input logic             rd_ok
);

  localparam int NCHAR = DEPTH * (SW / 4);
  localparam int HW    = $clog2(NCHAR + 2);

  logic [HW-1:0] hcnt_q;
  logic          taint_q, len_ok_q, clean_q;
  logic          digit, letter;

  assign digit  = (rx_byte >= 8'h30) && (rx_byte < 8'h3A);
  assign letter = (rx_byte > 8'h40) && (rx_byte < 8'h47);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt_q   <= '0;
      taint_q  <= 1'b0;
      len_ok_q <= 1'b0;
      clean_q  <= 1'b0;
    end else if (rx_err) begin
      taint_q <= 1'b1;
    end else if (rx_vld) begin
      if (rx_byte == 8'h0A) begin
        len_ok_q <= (hcnt_q == HW'(NCHAR));
        clean_q  <= !taint_q;
        hcnt_q   <= '0;
        taint_q  <= 1'b0;
      end else if ((digit || letter) && (hcnt_q != HW'(NCHAR + 1))) begin
        hcnt_q <= hcnt_q + 1'b1;
      end
    end
  end

  // R6
  fv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |=> !frame_valid);

  // R6
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |-> frame_count == CNT_W'($past(frame_count) + 1'b1));

  // R6
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_valid |-> $stable(frame_count));

  // R8
  ok_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ok |=> rd_ok);

  // R8
  ok_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_ok) |-> frame_valid);

  // R3
  len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |-> len_ok_q);

  // R5
  taint_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |-> clean_q);

endmodule

bind hexcap_rx hexcap_rx_chk #(.DEPTH(DEPTH), .SW(SW), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rx_vld      (rx_vld),
  .rx_err      (rx_err),
  .rx_byte     (rx_byte),
  .frame_valid (frame_valid),
  .frame_count (frame_count),
  .rd_ok       (rd_ok)
);

// File: tb/hexcap_rx_bench.sv
module hexcap_rx_bench;

  localparam int BAUD   = 19200;
  localparam int DIV    = 8;
  localparam int CLK_HZ = BAUD * DIV;
  localparam int DEPTH  = 8;
  localparam int SW     = 16;
  localparam int CNT_W  = 8;
  localparam int AW     = $clog2(DEPTH);

  typedef logic [DEPTH*SW-1:0] frame_t;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             serial_in;
  logic [AW-1:0]    rd_addr;
  logic [SW-1:0]    rd_data;
  logic             rd_ok;
  logic             frame_valid;
  logic [CNT_W-1:0] frame_count;
  logic [AW-1:0]    trig_idx;

  int     nchk  = 0;
  int     nfail = 0;
  bit     mon_busy = 1'b0;
  bit     done = 1'b0;
  int     exp_cnt = 0;
  frame_t exp_q[$];
  frame_t good;
  logic [SW-1:0] pat [DEPTH];

  always #2 clk = !clk;

  hexcap_rx #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .DEPTH(DEPTH), .SW(SW), .CNT_W(CNT_W))
  u_hexcap_rx (
    .clk(clk), .rst_n(rst_n), .serial_in(serial_in), .rd_addr(rd_addr),
    .rd_data(rd_data), .rd_ok(rd_ok), .frame_valid(frame_valid),
    .frame_count(frame_count), .trig_idx(trig_idx)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  endtask

  function automatic logic [7:0] hexch(input logic [3:0] n);
    return (n < 4'd10) ? 8'h30 + 8'(n) : 8'h41 + 8'(n) - 8'd10;
  endfunction

  // R1: 8N1, LSB first
  task automatic send_byte(input logic [7:0] b, input bit stop_ok);
    @(negedge clk) serial_in = 1'b0;
    repeat (DIV) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      serial_in = b[i];
      repeat (DIV) @(negedge clk);
    end
    serial_in = stop_ok;
    repeat (DIV) @(negedge clk);
    serial_in = 1'b1;
    if (!stop_ok) repeat (2 * DIV) @(negedge clk);
  endtask

  function automatic frame_t pack_pat();
    frame_t f;
    for (int k = 0; k < DEPTH; k++) f[k*SW +: SW] = pat[k];
    return f;
  endfunction

  // modes: 0 clean, 1 short, 2 long, 3 bad stop byte, 4 lowercase digit, 5 CR/space noise
  task automatic send_frame(input int mode, input bit accept);
    if (accept) exp_q.push_back(pack_pat());
    for (int k = 0; k < DEPTH; k++) begin
      for (int n = 0; n < 4; n++) begin
        logic [3:0] nb;
        nb = pat[k][SW-1-4*n -: 4];
        if (mode == 1 && k == DEPTH - 1 && n == 3) continue;
        if (mode == 4 && k == 0 && n == 0) send_byte(8'h61 + 8'(nb) - 8'd10, 1'b1);
        else send_byte(hexch(nb), 1'b1);
      end
      if (mode == 5) send_byte((k % 2 == 0) ? 8'h0D : 8'h20, 1'b1);
      if (mode == 3 && k == 2) send_byte(8'h20, 1'b0);
    end
    if (mode == 2) send_byte(8'h30, 1'b1);
    send_byte(8'h0D, 1'b1);
    send_byte(8'h0A, 1'b1);
  endtask

  task automatic read_cmp(input frame_t f, input string req);
    for (int a = 0; a < DEPTH; a++) begin
      @(negedge clk) rd_addr = AW'(a);
      @(negedge clk);
      chk(req, 32'(rd_data), 32'(f[a*SW +: SW]));
    end
  endtask

  // monitor: pops the expected frame on every commit and compares
  initial begin
    forever begin
      @(negedge clk);
      if (frame_valid === 1'b1) begin
        mon_busy = 1'b1;
        exp_cnt++;
        chk("R6 frame_count step", 32'(frame_count), 32'(CNT_W'(exp_cnt)));
        if (exp_q.size() == 0) begin
          chk("R3 unexpected commit", 32'd1, 32'd0);
        end else begin
          good = exp_q.pop_front();
          @(negedge clk);
          chk("R6 pulse one cycle", 32'(frame_valid), 32'd0);
          read_cmp(good, "R2 R7 sample readback");
        end
        mon_busy = 1'b0;
      end
    end
  end

  task automatic wait_commit();
    int t;
    t = 0;
    while ((exp_q.size() != 0 || mon_busy) && t < 400) begin
      @(negedge clk);
      t++;
    end
    chk("R3 R6 commit seen", 32'(exp_q.size()), 32'd0);
  endtask

  task automatic check_reject(input string req);
    int c0;
    c0 = exp_cnt;
    repeat (100) @(negedge clk);
    chk(req, 32'(frame_count), 32'(CNT_W'(c0)));
    read_cmp(good, "R7 read bank kept after discard");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    serial_in = 1'b1;
    rd_addr = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    // R8 / R9 reset state
    chk("R8 rd_ok after reset", 32'(rd_ok), 32'd0);
    chk("R8 frame_count after reset", 32'(frame_count), 32'd0);
    chk("R6 frame_valid idle", 32'(frame_valid), 32'd0);
    chk("R9 trig_idx", 32'(trig_idx), 32'(DEPTH / 2));

    // R2: nibble ordering and extremes
    pat[0] = 16'h0000; pat[1] = 16'hFFFF; pat[2] = 16'h1234; pat[3] = 16'hABCD;
    pat[4] = 16'h8001; pat[5] = 16'h5A5A; pat[6] = 16'hC3F0; pat[7] = 16'h0F0F;
    send_frame(0, 1'b1);
    wait_commit();
    chk("R8 rd_ok after commit", 32'(rd_ok), 32'd1);

    for (int k = 0; k < DEPTH; k++) pat[k] = 16'hE000 ^ 16'(k * 16'h1111);
    send_frame(1, 1'b0);
    check_reject("R3 short frame discarded");
    send_frame(2, 1'b0);
    check_reject("R3 long frame discarded");
    send_frame(3, 1'b0);
    check_reject("R5 bad stop bit discards frame");
    send_frame(4, 1'b0);
    check_reject("R4 lowercase not counted");

    // R4: noise bytes inside a frame are skipped
    send_frame(5, 1'b1);
    wait_commit();

    // R5: the frame after a broken one is accepted again
    for (int k = 0; k < DEPTH; k++) pat[k] = 16'(k * 16'h2468 + 16'h0137);
    send_frame(0, 1'b1);
    wait_commit();
    chk("R6 final frame_count", 32'(frame_count), 32'd3);
    chk("R9 trig_idx steady", 32'(trig_idx), 32'(DEPTH / 2));
    finish_run();
  end

endmodule